// File: doc/BRIEF.md
# Alignment Marker Format Translator

This block converts alignment markers between the 66-bit form used on PCS lanes and the 64-bit payload form carried inside the FEC stream. It handles one marker per clock in each direction.

On the transmit path it takes a 66-bit marker, its lane index (0 to 19) and a valid strobe, and returns the 64-bit payload one clock later. On the receive path it takes a 64-bit payload with its lane index and returns the rebuilt 66-bit marker. It also flags payloads whose two marker triples are not bitwise complements of each other.

A mode input selects between two formats:
- **Legacy:** the marker octets pass straight through.
- **New format:** lanes 0 to 3 carry one fixed common pattern. Lanes 4 to 19 have their two three-octet marker groups exchanged. Because of this exchange, a device using one format cannot lock onto markers sent in the other.

The check-parity octets always pass through unchanged.

Top module: `am_fmt_xlat`

## Requirements
- R1: Each output valid strobe (`tx_vld_o`, `rx_vld_o`) is high exactly one clock after its input valid strobe was sampled high, and low one clock after it was sampled low.
- R2: While `rst_n` is low, every output is zero, including valid strobes, data and the mismatch flag.
- R3: Transmit output bits 31:24 equal input bits 33:26, and output bits 63:56 equal input bits 65:58. Receive output bits 33:26 equal input bits 31:24, and output bits 65:58 equal input bits 63:56. This holds in every mode and on every lane.
- R4: In legacy mode (`fmt_new_i`=0), transmit output bits 23:0 equal input bits 25:2, and output bits 55:32 equal input bits 57:34, on every lane.
- R5: In new-format mode on lanes 0 to 3, transmit output bits 23:0 are 24'h2168C1 (octets C1, 68, 21, lowest first). Output bits 55:32 are 24'hDE973E. The input marker octets are ignored.
- R6: In new-format mode on lanes 4 to 19, transmit output bits 23:0 equal input bits 57:34, and output bits 55:32 equal input bits 25:2.
- R7: Lane indices 20 to 31 use the legacy octet mapping in both directions, whatever the mode.
- R8: Receive output bits 25:2 equal input bits 23:0, and output bits 57:34 equal input bits 55:32. The one exception is new-format mode on lanes 4 to 19, where the two groups are exchanged back: output 25:2 takes input 55:32, and output 57:34 takes input 23:0.
- R9: Receive output bits 1:0 are 2'b10 on every marker produced.
- R10: `rx_mis_o` is high together with `rx_vld_o` when the received bits 23:0 differ from the bitwise inverse of bits 55:32. It is low otherwise, and always low when `rx_vld_o` is low.
- R11: When an input valid strobe is sampled low, the matching data output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_new_i | input | 1 | 1 selects new format, 0 selects legacy |
| tx_vld_i | input | 1 | Transmit marker valid |
| tx_lane_i | input | 5 | Transmit PCS lane index |
| tx_am_i | input | 66 | Transmit 66-bit marker |
| tx_vld_o | output | 1 | Transmit payload valid |
| tx_amp_o | output | 64 | Transmit 64-bit payload |
| rx_vld_i | input | 1 | Receive payload valid |
| rx_lane_i | input | 5 | Receive PCS lane index |
| rx_amp_i | input | 64 | Receive 64-bit payload |
| rx_vld_o | output | 1 | Rebuilt marker valid |
| rx_am_o | output | 66 | Rebuilt 66-bit marker |
| rx_mis_o | output | 1 | Complement mismatch flag |

## Verification
A wrong lane class or mode decode appears on the very next clock as marker triples that are swapped, forced or left alone when they should not be. A slip in the octet slicing shows up as corrupted parity octets in the same cycle. Faults in the hold-enable or valid pipeline show up as data that changes, or a strobe that appears, one clock after an idle input. Vectors mix complementary and non-complementary triples, so a mismatch fault is visible on the first marker checked.

// File: rtl/am_xlat_pkg.sv
package am_xlat_pkg;
  localparam int AM_W     = 66;
  localparam int AMP_W    = 64;
  localparam int TRI_W    = 24;
  localparam int OCT_W    = 8;
  localparam logic [TRI_W-1:0] CM_LO = 24'h2168C1;
  localparam logic [TRI_W-1:0] CM_HI = 24'hDE973E;
  localparam logic [1:0]       SYNC_AM = 2'b10;

  typedef enum logic [1:0] {
    LC_COMMON = 2'd0,
    LC_UNIQUE = 2'd1,
    LC_RANGE  = 2'd2
  } lane_cls_e;
endpackage

// File: rtl/am_rst_sync.sv
module am_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/am_lane_class.sv
module am_lane_class
  import am_xlat_pkg::*;
#(
  parameter int N_LANES    = 20,
  parameter int N_CM_LANES = 4,
  parameter int LANE_W     = 5
) (
  input  logic [LANE_W-1:0] lane_i,
  output lane_cls_e         cls_o
);
  localparam logic [LANE_W-1:0] CM_LIM = LANE_W'(N_CM_LANES);
  localparam logic [LANE_W-1:0] LN_LIM = LANE_W'(N_LANES);

  always_comb begin
    if (lane_i < CM_LIM)      cls_o = LC_COMMON;
    else if (lane_i < LN_LIM) cls_o = LC_UNIQUE;
    else                      cls_o = LC_RANGE;
  end
endmodule

// File: rtl/am_tx_map.sv
module am_tx_map
  import am_xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             new_fmt_i,
  input  logic             vld_i,
  input  lane_cls_e        cls_i,
  input  logic [AM_W-1:0]  am_i,
  output logic             vld_o,
  output logic [AMP_W-1:0] amp_o
);
  logic [TRI_W-1:0] in_lo, in_hi, nxt_lo, nxt_hi;
  logic [OCT_W-1:0] in_b3, in_b7;
  logic [AMP_W-1:0] amp_d;
  logic             unused_sh;

  assign in_lo     = am_i[25:2];
  assign in_b3     = am_i[33:26];
  assign in_hi     = am_i[57:34];
  assign in_b7     = am_i[65:58];
  assign unused_sh = ^am_i[1:0];

  always_comb begin
    nxt_lo = in_lo;
    nxt_hi = in_hi;
    if (new_fmt_i) begin
      unique case (cls_i)
        LC_COMMON: begin nxt_lo = CM_LO; nxt_hi = CM_HI; end
        LC_UNIQUE: begin nxt_lo = in_hi; nxt_hi = in_lo; end
        default:   begin nxt_lo = in_lo; nxt_hi = in_hi; end
      endcase
    end
    amp_d = {in_b7, nxt_hi, in_b3, nxt_lo};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      amp_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) amp_o <= amp_d;
    end
  end

  AST_TX_VLD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o); // R1
  AST_TX_BIP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (amp_o[31:24] == $past(am_i[33:26])) && (amp_o[63:56] == $past(am_i[65:58]))); // R3
  AST_TX_CM_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && new_fmt_i && cls_i == LC_COMMON) |=> (amp_o[23:0] == CM_LO) && (amp_o[55:32] == CM_HI)); // R5
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(amp_o)); // R11
endmodule

// File: rtl/am_rx_map.sv
module am_rx_map
  import am_xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             new_fmt_i,
  input  logic             vld_i,
  input  lane_cls_e        cls_i,
  input  logic [AMP_W-1:0] amp_i,
  output logic             vld_o,
  output logic [AM_W-1:0]  am_o,
  output logic             mis_o
);
  logic [TRI_W-1:0] in_lo, in_hi, nxt_lo, nxt_hi;
  logic [OCT_W-1:0] in_b3, in_b7;
  logic [AM_W-1:0]  am_d;
  logic             mis_d;

  assign in_lo = amp_i[23:0];
  assign in_b3 = amp_i[31:24];
  assign in_hi = amp_i[55:32];
  assign in_b7 = amp_i[63:56];

  always_comb begin
    nxt_lo = in_lo;
    nxt_hi = in_hi;
    if (new_fmt_i && cls_i == LC_UNIQUE) begin
      nxt_lo = in_hi;
      nxt_hi = in_lo;
    end
    am_d  = {in_b7, nxt_hi, in_b3, nxt_lo, SYNC_AM};
    mis_d = vld_i && (in_lo != ~in_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      mis_o <= 1'b0;
      am_o  <= '0;
    end else begin
      vld_o <= vld_i;
      mis_o <= mis_d;
      if (vld_i) am_o <= am_d;
    end
  end

  AST_RX_VLD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !vld_o); // R1
  AST_RX_BIP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (am_o[33:26] == $past(amp_i[31:24])) && (am_o[65:58] == $past(amp_i[63:56]))); // R3
  AST_RX_SYNC_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> am_o[1:0] == SYNC_AM); // R9
  AST_RX_MIS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    mis_o |-> vld_o); // R10
endmodule

// File: rtl/am_fmt_xlat.sv
module am_fmt_xlat
  import am_xlat_pkg::*;
#(
  parameter int N_LANES    = 20,
  parameter int N_CM_LANES = 4,
  localparam int LANE_W    = $clog2(N_LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_new_i,
  input  logic              tx_vld_i,
  input  logic [LANE_W-1:0] tx_lane_i,
  input  logic [65:0]       tx_am_i,
  output logic              tx_vld_o,
  output logic [63:0]       tx_amp_o,
  input  logic              rx_vld_i,
  input  logic [LANE_W-1:0] rx_lane_i,
  input  logic [63:0]       rx_amp_i,
  output logic              rx_vld_o,
  output logic [65:0]       rx_am_o,
  output logic              rx_mis_o
);
  logic      rst_n_s;
  lane_cls_e tx_cls, rx_cls;

  am_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  am_lane_class #(.N_LANES(N_LANES), .N_CM_LANES(N_CM_LANES), .LANE_W(LANE_W)) i_tx_cls (
    .lane_i(tx_lane_i), .cls_o(tx_cls)
  );

  am_lane_class #(.N_LANES(N_LANES), .N_CM_LANES(N_CM_LANES), .LANE_W(LANE_W)) i_rx_cls (
    .lane_i(rx_lane_i), .cls_o(rx_cls)
  );

  am_tx_map i_tx_map (
    .clk(clk), .rst_n(rst_n_s), .new_fmt_i(fmt_new_i), .vld_i(tx_vld_i),
    .cls_i(tx_cls), .am_i(tx_am_i), .vld_o(tx_vld_o), .amp_o(tx_amp_o)
  );

  am_rx_map i_rx_map (
    .clk(clk), .rst_n(rst_n_s), .new_fmt_i(fmt_new_i), .vld_i(rx_vld_i),
    .cls_i(rx_cls), .amp_i(rx_amp_i), .vld_o(rx_vld_o), .am_o(rx_am_o),
    .mis_o(rx_mis_o)
  );

  AST_RST_CLEAR: assert property (@(posedge clk)
    !rst_n |-> !tx_vld_o && !rx_vld_o && !rx_mis_o && tx_amp_o == '0 && rx_am_o == '0); // R2
endmodule

// File: tb/test_am_fmt_xlat.sv
module test_am_fmt_xlat;
  typedef struct packed {
    logic        mode;
    logic [4:0]  lane;
    logic [65:0] tx_am;
    logic [63:0] tx_exp;
    logic [63:0] rx_amp;
    logic [65:0] rx_exp;
    logic        rx_mis;
  } vec_t;

  localparam logic [65:0] AM_A = {8'h5A, 24'h789ABC, 8'hA5, 24'h123456, 2'b01};
  localparam logic [65:0] AM_B = {8'h22, 24'hF0F0F0, 8'h11, 24'h0F0F0F, 2'b11};
  localparam logic [63:0] P1   = {8'h5A, 24'h789ABC, 8'hA5, 24'h123456};
  localparam logic [63:0] P2   = {8'h33, 24'h0907F5, 8'h44, 24'hF6F80A};
  localparam logic [63:0] PC   = {8'h00, 24'hDE973E, 8'h00, 24'h2168C1};
  localparam int NV = 8;

  // R4 R5 R6 R7 R8 R9 R10 vectors
  localparam vec_t VT [NV] = '{
    '{1'b0, 5'd5,  AM_A, {8'h5A,24'h789ABC,8'hA5,24'h123456}, P1, {P1,2'b10}, 1'b1},
    '{1'b1, 5'd5,  AM_A, {8'h5A,24'h123456,8'hA5,24'h789ABC}, P1, {8'h5A,24'h123456,8'hA5,24'h789ABC,2'b10}, 1'b1},
    '{1'b1, 5'd0,  AM_A, {8'h5A,24'hDE973E,8'hA5,24'h2168C1}, PC, {PC,2'b10}, 1'b0},
    '{1'b1, 5'd3,  AM_B, {8'h22,24'hDE973E,8'h11,24'h2168C1}, P2, {P2,2'b10}, 1'b0},
    '{1'b1, 5'd19, AM_B, {8'h22,24'h0F0F0F,8'h11,24'hF0F0F0}, P2, {8'h33,24'hF6F80A,8'h44,24'h0907F5,2'b10}, 1'b0},
    '{1'b1, 5'd20, AM_B, {8'h22,24'hF0F0F0,8'h11,24'h0F0F0F}, P1, {P1,2'b10}, 1'b1},
    '{1'b0, 5'd0,  AM_B, {8'h22,24'hF0F0F0,8'h11,24'h0F0F0F}, P2, {P2,2'b10}, 1'b0},
    '{1'b1, 5'd4,  AM_A, {8'h5A,24'h123456,8'hA5,24'h789ABC}, P1, {8'h5A,24'h123456,8'hA5,24'h789ABC,2'b10}, 1'b1}
  };

  logic        clk, rst_n, fmt_new_i, tx_vld_i, rx_vld_i;
  logic [4:0]  tx_lane_i, rx_lane_i;
  logic [65:0] tx_am_i;
  logic [63:0] rx_amp_i;
  logic        tx_vld_o, rx_vld_o, rx_mis_o;
  logic [63:0] tx_amp_o;
  logic [65:0] rx_am_o;
  int n_chk, n_fail;

  am_fmt_xlat i_am_fmt_xlat (
    .clk(clk), .rst_n(rst_n), .fmt_new_i(fmt_new_i),
    .tx_vld_i(tx_vld_i), .tx_lane_i(tx_lane_i), .tx_am_i(tx_am_i),
    .tx_vld_o(tx_vld_o), .tx_amp_o(tx_amp_o),
    .rx_vld_i(rx_vld_i), .rx_lane_i(rx_lane_i), .rx_amp_i(rx_amp_i),
    .rx_vld_o(rx_vld_o), .rx_am_o(rx_am_o), .rx_mis_o(rx_mis_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [65:0] act, input logic [65:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; fmt_new_i = 1'b0; tx_vld_i = 1'b0; rx_vld_i = 1'b0;
    tx_lane_i = '0; rx_lane_i = '0; tx_am_i = '0; rx_amp_i = '0;
    #5;
    chk("R2 reset tx_vld", 66'(tx_vld_o), 66'd0);
    chk("R2 reset rx_vld", 66'(rx_vld_o), 66'd0);
    chk("R2 reset tx_amp", 66'(tx_amp_o), 66'd0);
    chk("R2 reset rx_am", rx_am_o, 66'd0);
    chk("R2 reset mis", 66'(rx_mis_o), 66'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      fmt_new_i = VT[i].mode;
      tx_vld_i = 1'b1; tx_lane_i = VT[i].lane; tx_am_i = VT[i].tx_am;
      rx_vld_i = 1'b1; rx_lane_i = VT[i].lane; rx_amp_i = VT[i].rx_amp;
      @(negedge clk);
      chk("R1 tx_vld", 66'(tx_vld_o), 66'd1);
      chk("R1 rx_vld", 66'(rx_vld_o), 66'd1);
      chk("R3 R4 R5 R6 R7 tx_amp", 66'(tx_amp_o), 66'(VT[i].tx_exp));
      chk("R3 R7 R8 R9 rx_am", rx_am_o, VT[i].rx_exp);
      chk("R10 rx_mis", 66'(rx_mis_o), 66'(VT[i].rx_mis));
    end

    // R11 hold and R1 falling edge: change data with valid low
    tx_vld_i = 1'b0; rx_vld_i = 1'b0;
    tx_am_i = AM_B; rx_amp_i = P2; fmt_new_i = 1'b0;
    @(negedge clk);
    chk("R1 tx_vld low", 66'(tx_vld_o), 66'd0);
    chk("R1 rx_vld low", 66'(rx_vld_o), 66'd0);
    chk("R11 tx hold", 66'(tx_amp_o), 66'(VT[NV-1].tx_exp));
    chk("R11 rx hold", rx_am_o, VT[NV-1].rx_exp);
    chk("R10 mis low idle", 66'(rx_mis_o), 66'd0);

    // R5 input ignored: different input on lane 1 in new mode gives same pattern
    fmt_new_i = 1'b1; tx_vld_i = 1'b1; tx_lane_i = 5'd1;
    tx_am_i = {8'hC3, 24'hFFFFFF, 8'h3C, 24'h000000, 2'b10};
    @(negedge clk);
    chk("R5 lane1 forced", 66'(tx_amp_o), 66'({8'hC3,24'hDE973E,8'h3C,24'h2168C1}));
    // R7 lane 31 passthrough
    tx_lane_i = 5'd31;
    @(negedge clk);
    chk("R7 lane31 tx", 66'(tx_amp_o), 66'({8'hC3,24'hFFFFFF,8'h3C,24'h000000}));
    tx_vld_i = 1'b0;

    // R2 asynchronous reset mid-operation
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    chk("R2 mid reset tx_amp", 66'(tx_amp_o), 66'd0);
    chk("R2 mid reset rx_am", rx_am_o, 66'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule